// File: doc/BRIEF.md
# NOR Flash Block Unlock Initialization Sequencer

This block prepares a NOR flash device once after power-up. A single start pulse launches a walk over every erase block, from index zero to the last configured index. For each block it drives a short, fixed series of 16-bit command writes to the block's base address. It reads the device status word and waits on the ready flag. If the device reports an erase that was suspended earlier, the block resumes that erase and waits for it to complete. Each block is then returned to array-read mode before the walk moves to the next one.

The flash bus is a minimal one. A one-cycle write strobe carries an address and write data. A one-cycle read request gets its read data back on the following cycle. The base address of a block is its index shifted left by a parameter that gives log2 of the block size. Busy stays high for the whole walk, and done pulses once at the end.

Top module: `flash_unlock_seq`

## Requirements
- R1: A start pulse while idle begins a walk that visits blocks 0, 1, ..., NUM_BLOCKS-1 in ascending order. Every bus access for block b uses address b << BLK_SHIFT.
- R2: Each block's commands begin with four writes in this order: 0x0050 (clear status), 0x00FF (array read), 0x0060 (configuration setup), 0x00D0 (unlock confirm).
- R3: After the unlock write, the block reads status repeatedly until bit 7 (ready) of the read data is 1. It issues no further write before that ready value has been returned, and bit 6 has no effect on this wait.
- R4: After ready, the block writes 0x0070 (status mode) and reads status once. If bit 6 of that read is 1 (erase suspended), it writes 0x00D0 (resume) and then 0x0070, then reads status until bit 7 is 1.
- R5: If bit 6 of the single status read is 0, no resume writes are issued for that block.
- R6: Every block's command series ends with a write of 0x00FF, after all of its polling has completed.
- R7: busy is 1 from the cycle after the accepted start through the cycle of the last write. done is 1 for exactly one cycle, the cycle right after the last block's final write, and busy is 0 in that cycle.
- R8: Each write is a one-cycle fl_we strobe. fl_we and fl_re are never 1 together. Read data is taken in the cycle after fl_re.
- R9: A start pulse during a walk has no effect: the walk's command series and the single done pulse are unchanged.
- R10: During and right after reset, busy, done, fl_we and fl_re are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin the walk (taken only when idle) |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse when every block is handled |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read request |
| fl_addr | output | ADDR_W | Flash address (block base) |
| fl_wdata | output | 16 | Flash write data |
| fl_rdata | input | 16 | Flash read data, valid the cycle after fl_re |

## Verification
The flash model keeps the ready bit low for a different number of reads on each block. While it is not ready it returns bit 6 set. A design that tested the wrong bit, or that moved on after a single read, would issue its next write while the model is still busy. Blocks with and without a suspended erase are mixed within one walk. A design that skipped the resume would miss the 0x00D0/0x0070 pair, and one that always resumed would add writes that the scoreboard does not expect. A second start in the middle of a walk, together with the exact cycle of done relative to the last write, catches designs that restart the walk, pulse done twice, or end one cycle off.

// File: rtl/fus_pkg.sv
package fus_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CLR, ST_ARR0, ST_CFG, ST_UNL, ST_P1_REQ, ST_P1_CHK, ST_RDS,
    ST_ST_REQ, ST_ST_CHK, ST_RES, ST_RDS2, ST_P2_REQ, ST_P2_CHK, ST_ARR1, ST_DONE
  } fus_state_e;

  localparam logic [15:0] CMD_CLR   = 16'h0050;
  localparam logic [15:0] CMD_ARRAY = 16'h00FF;
  localparam logic [15:0] CMD_CFG   = 16'h0060;
  localparam logic [15:0] CMD_CONF  = 16'h00D0;
  localparam logic [15:0] CMD_STAT  = 16'h0070;

  localparam int RDY_BIT  = 7;
  localparam int SUSP_BIT = 6;
endpackage

// File: rtl/fus_blk_ctr.sv
module fus_blk_ctr #(
  parameter int NUM_BLOCKS = 8,
  parameter int BLK_SHIFT  = 16,
  parameter int ADDR_W     = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adv,
  output logic              last,
  output logic [ADDR_W-1:0] base_addr
);
  localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BLOCKS - 1);

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              idx_en;
  logic [ADDR_W-1:0] idx_ext;

  assign idx_en = clr | adv;

  always_comb begin
    idx_d = idx_q;
    if (clr)      idx_d = '0;
    else if (adv) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  assign last      = (idx_q == LAST_IDX);
  assign idx_ext   = ADDR_W'(idx_q);
  assign base_addr = idx_ext << BLK_SHIFT;
endmodule

// File: rtl/fus_step_fsm.sv
module fus_step_fsm
  import fus_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        last,
  input  logic [15:0] rdata,
  output logic        we,
  output logic        re,
  output logic [15:0] wdata,
  output logic        busy,
  output logic        done,
  output logic        ctr_clr,
  output logic        ctr_adv
);
  fus_state_e state_q, state_d;
  logic       rdy, susp;
  logic       unused_rdata;

  assign rdy          = rdata[RDY_BIT];
  assign susp         = rdata[SUSP_BIT];
  assign unused_rdata = ^{rdata[15:8], rdata[5:0]};

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start) state_d = ST_CLR;
      ST_CLR:    state_d = ST_ARR0;
      ST_ARR0:   state_d = ST_CFG;
      ST_CFG:    state_d = ST_UNL;
      ST_UNL:    state_d = ST_P1_REQ;
      ST_P1_REQ: state_d = ST_P1_CHK;
      ST_P1_CHK: state_d = rdy ? ST_RDS : ST_P1_REQ;
      ST_RDS:    state_d = ST_ST_REQ;
      ST_ST_REQ: state_d = ST_ST_CHK;
      ST_ST_CHK: state_d = susp ? ST_RES : ST_ARR1;
      ST_RES:    state_d = ST_RDS2;
      ST_RDS2:   state_d = ST_P2_REQ;
      ST_P2_REQ: state_d = ST_P2_CHK;
      ST_P2_CHK: state_d = rdy ? ST_ARR1 : ST_P2_REQ;
      ST_ARR1:   state_d = last ? ST_DONE : ST_CLR;
      ST_DONE:   state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    we    = 1'b0;
    wdata = CMD_ARRAY;
    unique case (state_q)
      ST_CLR:  begin we = 1'b1; wdata = CMD_CLR;   end
      ST_ARR0: begin we = 1'b1; wdata = CMD_ARRAY; end
      ST_CFG:  begin we = 1'b1; wdata = CMD_CFG;   end
      ST_UNL:  begin we = 1'b1; wdata = CMD_CONF;  end
      ST_RDS:  begin we = 1'b1; wdata = CMD_STAT;  end
      ST_RES:  begin we = 1'b1; wdata = CMD_CONF;  end
      ST_RDS2: begin we = 1'b1; wdata = CMD_STAT;  end
      ST_ARR1: begin we = 1'b1; wdata = CMD_ARRAY; end
      default: ;
    endcase
  end

  assign re      = (state_q == ST_P1_REQ) || (state_q == ST_ST_REQ) || (state_q == ST_P2_REQ);
  assign busy    = (state_q != ST_IDLE) && (state_q != ST_DONE);
  assign done    = (state_q == ST_DONE);
  assign ctr_clr = (state_q == ST_IDLE) && start;
  assign ctr_adv = (state_q == ST_ARR1) && !last;
endmodule

// File: rtl/flash_unlock_seq.sv
module flash_unlock_seq #(
  parameter int NUM_BLOCKS = 8,
  parameter int BLK_SHIFT  = 16,
  parameter int ADDR_W     = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fl_we,
  output logic              fl_re,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [15:0]       fl_wdata,
  input  logic [15:0]       fl_rdata
);
  logic ctr_clr, ctr_adv, last;

  fus_blk_ctr #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .BLK_SHIFT (BLK_SHIFT),
    .ADDR_W    (ADDR_W)
  ) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ctr_clr),
    .adv      (ctr_adv),
    .last     (last),
    .base_addr(fl_addr)
  );

  fus_step_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .last   (last),
    .rdata  (fl_rdata),
    .we     (fl_we),
    .re     (fl_re),
    .wdata  (fl_wdata),
    .busy   (busy),
    .done   (done),
    .ctr_clr(ctr_clr),
    .ctr_adv(ctr_adv)
  );
endmodule

// File: rtl/fus_chk.sv
module fus_chk #(
  parameter int BLK_SHIFT = 16,
  parameter int ADDR_W    = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              fl_we,
  input logic              fl_re,
  input logic [ADDR_W-1:0] fl_addr
);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((64'd1 << BLK_SHIFT) - 64'd1);

  // R8
  no_we_re_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

  // R8
  we_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we || fl_re) |-> busy);

  // R1
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we || fl_re) |-> ((fl_addr & LOW_MASK) == '0));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(fl_we)));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));
endmodule

bind flash_unlock_seq fus_chk #(.BLK_SHIFT(BLK_SHIFT), .ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy   (busy),
  .done   (done),
  .fl_we  (fl_we),
  .fl_re  (fl_re),
  .fl_addr(fl_addr)
);

// File: tb/flash_unlock_seq_tb.sv
module flash_unlock_seq_tb;
  localparam int NB = 4;
  localparam int SH = 12;
  localparam int AW = 16;

  logic          clk, rst_n, start;
  logic          busy, done, fl_we, fl_re;
  logic [AW-1:0] fl_addr;
  logic [15:0]   fl_wdata;
  logic [15:0]   fl_rdata;

  flash_unlock_seq #(.NUM_BLOCKS(NB), .BLK_SHIFT(SH), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int last_we_cyc = -10;
  int done_cnt = 0;

  typedef struct { logic [AW-1:0] a; logic [15:0] d; } wr_t;
  wr_t exp_q[$];

  int wait1 [NB];
  int wait2 [NB];
  bit susp  [NB];

  // flash model
  int phase = 0;
  int remain = 0;
  bit pending = 0;
  logic [15:0] prev_wd = 16'h0000;
  int blk = 0;

  always @(posedge clk) begin
    if (fl_we) begin
      blk = int'(fl_addr >> SH) % NB;
      if (fl_wdata == 16'h00D0 && prev_wd == 16'h0060) begin
        phase = 1; remain = wait1[blk]; pending = 1;
      end else if (fl_wdata == 16'h0070 && phase == 1) phase = 2;
      else if (fl_wdata == 16'h00D0 && phase == 2) phase = 3;
      else if (fl_wdata == 16'h0070 && phase == 3) begin
        phase = 4; remain = wait2[blk]; pending = 1;
      end else if (fl_wdata == 16'h00FF) phase = 0;
      prev_wd = fl_wdata;
    end
    if (fl_re) begin
      if (phase == 1 || phase == 4) begin
        if (remain > 0) begin
          remain = remain - 1;
          fl_rdata <= 16'h0040;
        end else begin
          pending = 0;
          fl_rdata <= (phase == 1 && susp[blk]) ? 16'h00C0 : 16'h0080;
        end
      end else if (phase == 2) begin
        fl_rdata <= susp[blk] ? 16'h00C0 : 16'h0080;
      end else begin
        fl_rdata <= 16'h0000;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (fl_we) begin
        check(!fl_re, "R8 we with re", 1, 0);
        check(busy, "R7 busy during write", busy, 1);
        check(!pending, "R3 write before ready", pending, 0);
        if (exp_q.size() == 0) begin
          check(0, "R9 unexpected write", fl_wdata, 0);
        end else begin
          wr_t e;
          e = exp_q.pop_front();
          check(fl_addr == e.a, "R1 address", fl_addr, e.a);
          check(fl_wdata == e.d, "R2 R4 R5 R6 write data", fl_wdata, e.d);
        end
        last_we_cyc = cyc;
      end
      if (done) begin
        done_cnt++;
        check(!busy, "R7 busy low at done", busy, 0);
        check(exp_q.size() == 0, "R7 done before last write", exp_q.size(), 0);
        check(last_we_cyc == cyc - 1, "R7 done timing", cyc - last_we_cyc, 1);
      end
    end
  end

  task automatic push(input int b, input logic [15:0] d);
    wr_t w;
    w.a = AW'(b) << SH;
    w.d = d;
    exp_q.push_back(w);
  endtask

  task automatic walk(input int restart_at, output bit hung);
    int t;
    hung = 0;
    for (int b = 0; b < NB; b++) begin
      push(b, 16'h0050); push(b, 16'h00FF); push(b, 16'h0060); push(b, 16'h00D0);
      push(b, 16'h0070);
      if (susp[b]) begin push(b, 16'h00D0); push(b, 16'h0070); end
      push(b, 16'h00FF);
    end
    done_cnt = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy, "R7 busy after start", busy, 1);
    t = 0;
    while (done_cnt == 0 && t < 3000) begin
      @(negedge clk);
      t++;
      if (t == restart_at) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    if (done_cnt == 0) hung = 1;
    repeat (6) @(negedge clk);
    check(done_cnt == 1, "R9 done pulse count", done_cnt, 1);
    check(!busy, "R9 idle after walk", busy, 0);
    check(exp_q.size() == 0, "R6 all writes seen", exp_q.size(), 0);
  endtask

  bit hung;

  initial begin
    rst_n = 1'b0; start = 1'b0; fl_rdata = 16'h0000;
    for (int b = 0; b < NB; b++) begin wait1[b] = 0; wait2[b] = 0; susp[b] = 0; end
    repeat (3) @(negedge clk);
    check(!busy && !done && !fl_we && !fl_re, "R10 reset outputs",
          {busy, done, fl_we, fl_re}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !fl_we && !fl_re, "R10 after reset",
          {busy, done, fl_we, fl_re}, 0);

    // R5: no suspend, immediate ready
    walk(0, hung);
    if (hung) check(0, "R7 watchdog", 0, 1);

    // R3 R4: mixed waits and suspends
    wait1[0] = 3; wait1[1] = 1; wait1[2] = 5; wait1[3] = 0;
    susp[1] = 1; susp[3] = 1; wait2[1] = 4; wait2[3] = 0;
    if (!hung) walk(0, hung);
    if (hung) check(0, "R4 watchdog", 0, 1);

    // R9: restart request mid-walk, all suspended
    for (int b = 0; b < NB; b++) begin wait1[b] = b + 1; susp[b] = 1; wait2[b] = 2 * b; end
    if (!hung) walk(12, hung);
    if (hung) check(0, "R9 watchdog", 0, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule